// File: doc/BRIEF.md
# EPROM Program, Verify and Blank-Check Sequencer

This block runs a full-array test pass on a parallel UV-erasable EPROM with a byte-wide data bus. After `start` in the program flow, it visits every address from zero upward. At each address it raises the programming-voltage request, waits one settle cycle, and applies one program cycle that carries a selected data pattern. When the last address is done, it drops the programming voltage and reads every location back. Each byte read is compared with the pattern, bit by bit. The blank-check flow is started separately, once the array has been erased outside this block. It reads every location and expects all ones.

The block does not form the per-location pulse algorithm, the erase step, or the analog high voltage. It only asks for the high voltage through `vpp_hi`. The memory pins are not a stream: they follow the device's mode table cycle by cycle, so there is no valid/ready on any port. Status reports pass or fail, the first failing address and a saturating count of bad bits. A one-cycle `done` pulse marks the end of each phase. For the full 64K x 8 part, keep the defaults `ADDR_W=16` and `DATA_W=8`.

Top module: `eprom_sweep_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, the outputs are as follows until a start is accepted: `ce_n=1`, `oe_n=1`, `vpp_hi=0`, `wr_en=0`, `done=0`, `pass=1`, `fail_addr=0`, `err_bits=0`, `addr=0`.
- R2: A start seen while idle with `blank_run=0` runs a program phase and then a verify phase. With `blank_run=1` it runs only a blank-check phase. Each phase visits all 2^ADDR_W addresses once, in ascending order.
- R3: In the program phase, each address takes two cycles. The first is an inhibit cycle (`ce_n=1`, `vpp_hi=1`, `oe_n=1`, `wr_en=0`). The second is a program cycle (`ce_n=0`, `vpp_hi=1`, `oe_n=1`, `wr_en=1`, with the pattern byte on `wr_data`).
- R4: In a read phase, each address takes two cycles. The first is a standby cycle (`ce_n=1`, `oe_n=0`, `vpp_hi=0`). The second is an enable cycle (`ce_n=0`, `oe_n=0`). `rd_data` is sampled at the clock edge that ends the enable cycle, and `oe_n` is never low while `vpp_hi` is high.
- R5: `addr` changes only in a cycle where `ce_n` is 1.
- R6: A program cycle is always preceded by a cycle with `vpp_hi=1`. A read enable cycle is never preceded by a cycle with `vpp_hi=1`. This gives one settle cycle after every change of the programming-voltage level.
- R7: `pat_sel` is latched when a start is accepted. 00 is a checkerboard: 0xAA when `addr[0]` XOR `addr[ADDR_W/2]` is 0, and 0x55 otherwise. 01 is the inverse checkerboard. 10 is all 0x00. 11 is all 0xFF. The verify phase expects the same byte that was programmed.
- R8: The blank-check phase expects 0xFF at every address.
- R9: Any mismatching bit clears `pass` until the next accepted start. `fail_addr` holds the lowest address that mismatched.
- R10: `err_bits` adds the number of mismatching bits at every compare and saturates at 2^CNT_W-1.
- R11: `done` is a one-cycle pulse at the end of each phase: two pulses for the program flow and one for blank check. The status is final in the cycle of the last pulse.
- R12: A start while a flow is running is ignored. The running pattern, phases and results are unchanged.
- R13: An accepted start clears `pass` to 1 and `fail_addr` and `err_bits` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a flow when idle |
| blank_run | input | 1 | 1 selects the blank-check flow, 0 selects program then verify |
| pat_sel | input | 2 | Pattern code, latched at start |
| rd_data | input | DATA_W | Data read from the memory |
| addr | output | ADDR_W | Memory address |
| wr_data | output | DATA_W | Byte to program, zero outside program cycles |
| wr_en | output | 1 | Data bus is driven toward the memory |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable at logic level, active low |
| vpp_hi | output | 1 | Request to raise the shared enable pin to programming voltage |
| done | output | 1 | End-of-phase pulse |
| pass | output | 1 | No mismatch seen since the last start |
| fail_addr | output | ADDR_W | First failing address |
| err_bits | output | CNT_W | Saturating count of mismatching bits |

## Verification
The bench drives a behavioral memory in which programming can only clear bits. It can force chosen bits to read as one. All four pattern codes are programmed into an erased array and read back. The checkerboard and its inverse show whether the row-parity phase and the bit order are right. All-zero and all-one show whether the forced bits are found only where a zero was expected.

A blank check without erase, over a checkerboard, makes every location fail. This tests the first-address capture and saturation of the counter. A blank check after erase must pass. A second start while a flow runs must change neither the programmed bytes nor the results.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P_INH,
    ST_P_PULSE,
    ST_R_STBY,
    ST_R_EN
  } seq_state_t;

  typedef enum logic [1:0] {
    PAT_CHECKER     = 2'b00,
    PAT_CHECKER_INV = 2'b01,
    PAT_ZERO        = 2'b10,
    PAT_ONE         = 2'b11
  } pat_t;
endpackage

// File: rtl/eprom_pattern_gen.sv
module eprom_pattern_gen
  import eprom_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  pat_t              pat,
  input  logic              blank,
  input  logic              row_odd,
  output logic [DATA_W-1:0] exp_data
);
  logic [DATA_W-1:0] chk_word;

  for (genvar g = 0; g < DATA_W; g++) begin : g_chk
    assign chk_word[g] = 1'(g % 2);
  end

  always_comb begin
    if (blank) begin
      exp_data = '1;
    end else begin
      unique case (pat)
        PAT_CHECKER:     exp_data = row_odd ? ~chk_word : chk_word;
        PAT_CHECKER_INV: exp_data = row_odd ? chk_word : ~chk_word;
        PAT_ZERO:        exp_data = '0;
        default:         exp_data = '1;
      endcase
    end
  end
endmodule

// File: rtl/eprom_bit_tally.sv
module eprom_bit_tally #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cmp_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] exp_data,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [CNT_W-1:0]  err_bits
);
  localparam int PW = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] diff;
  logic [PW-1:0]     pop;
  logic [CNT_W:0]    sum;

  always_comb begin
    diff = rd_data ^ exp_data;
    pop  = '0;
    for (int i = 0; i < DATA_W; i++) pop = pop + PW'(diff[i]);
    sum = {1'b0, err_bits} + (CNT_W + 1)'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      err_bits  <= '0;
    end else if (cmp_en) begin
      if ((|diff) && !fail) begin
        fail      <= 1'b1;
        fail_addr <= addr;
      end
      err_bits <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/eprom_mode_fsm.sv
module eprom_mode_fsm
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              blank_run,
  output logic [ADDR_W-1:0] addr,
  output logic              accept,
  output logic              blank_q,
  output logic              ce_n,
  output logic              oe_n,
  output logic              vpp_hi,
  output logic              wr_en,
  output logic              cmp_en,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  seq_state_t state;
  logic       last;

  assign last   = (addr == LAST);
  assign accept = start && (state == ST_IDLE);
  assign ce_n   = !((state == ST_P_PULSE) || (state == ST_R_EN));
  assign vpp_hi = (state == ST_P_INH) || (state == ST_P_PULSE);
  assign oe_n   = !((state == ST_R_STBY) || (state == ST_R_EN));
  assign wr_en  = (state == ST_P_PULSE);
  assign cmp_en = (state == ST_R_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr    <= '0;
      blank_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          addr    <= '0;
          blank_q <= blank_run;
          state   <= blank_run ? ST_R_STBY : ST_P_INH;
        end
        ST_P_INH: state <= ST_P_PULSE;
        ST_P_PULSE: begin
          if (last) begin
            done  <= 1'b1;
            addr  <= '0;
            state <= ST_R_STBY;
          end else begin
            addr  <= addr + 1'b1;
            state <= ST_P_INH;
          end
        end
        ST_R_STBY: state <= ST_R_EN;
        default: begin
          if (last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            addr  <= addr + 1'b1;
            state <= ST_R_STBY;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eprom_sweep_seq.sv
module eprom_sweep_seq
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              blank_run,
  input  logic [1:0]        pat_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              ce_n,
  output logic              oe_n,
  output logic              vpp_hi,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [CNT_W-1:0]  err_bits
);
  localparam int ROW_BIT = ADDR_W / 2;

  logic              accept, blank_q, cmp_en, fail;
  logic [DATA_W-1:0] exp_data;
  pat_t              pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pat_q <= PAT_CHECKER;
    else if (accept) pat_q <= pat_t'(pat_sel);
  end

  eprom_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .blank_run(blank_run),
    .addr(addr), .accept(accept), .blank_q(blank_q),
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .wr_en(wr_en),
    .cmp_en(cmp_en), .done(done)
  );

  eprom_pattern_gen #(.DATA_W(DATA_W)) u_pat (
    .pat(pat_q), .blank(blank_q), .row_odd(addr[0] ^ addr[ROW_BIT]),
    .exp_data(exp_data)
  );

  eprom_bit_tally #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cmp_en(cmp_en),
    .addr(addr), .rd_data(rd_data), .exp_data(exp_data),
    .fail(fail), .fail_addr(fail_addr), .err_bits(err_bits)
  );

  assign wr_data = wr_en ? exp_data : '0;
  assign pass    = !fail;
endmodule

// File: rtl/eprom_sweep_seq_chk.sv
module eprom_sweep_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [CNT_W-1:0]  err_bits
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_pulse_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!ce_n && vpp_hi && oe_n));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !vpp_hi);

  assert_addr_ce_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> ce_n);

  assert_pulse_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(vpp_hi));

  assert_read_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !vpp_hi) |-> !$past(vpp_hi));

  assert_first_fail_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !start) |=> (!pass && $stable(fail_addr)));

  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bits == CNT_MAX && !start) |=> (err_bits == CNT_MAX));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind eprom_sweep_seq eprom_sweep_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wr_en(wr_en),
  .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .done(done), .pass(pass),
  .fail_addr(fail_addr), .err_bits(err_bits)
);

// File: tb/eprom_sweep_seq_test.sv
module eprom_sweep_seq_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int ROW = AW / 2;
  localparam int NVEC = 7;
  // {erase_first, fault_on, blank_run, pat_sel[1:0]}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0_0_00, 5'b0_0_1_00, 5'b1_0_1_00, 5'b1_0_0_01,
    5'b1_1_0_10, 5'b1_1_0_11, 5'b1_1_0_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, blank_run = 1'b0;
  logic [1:0] pat_sel = 2'b00;
  logic [DW-1:0] rd_data, wr_data;
  logic [AW-1:0] addr, fail_addr;
  logic wr_en, ce_n, oe_n, vpp_hi, done, pass;
  logic [CW-1:0] err_bits;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] stuck [DEPTH];
  logic fault_on = 1'b0;
  logic erase_req = 1'b0;

  int checks = 0, fails = 0;
  int done_total = 0, pulse_total = 0, read_total = 0;
  int v_addr = 0, v_settle = 0, v_mode = 0, v_done = 0;
  logic p_vpp = 1'b0, p_done = 1'b0;
  logic [AW-1:0] p_addr = '0;

  always #2.5 clk = ~clk;

  eprom_sweep_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blank_run(blank_run),
    .pat_sel(pat_sel), .rd_data(rd_data), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .done(done),
    .pass(pass), .fail_addr(fail_addr), .err_bits(err_bits)
  );

  // memory model: programming only clears bits, forced bits read as one
  assign rd_data = (!ce_n && !oe_n && !vpp_hi) ?
                   (mem[addr] | (fault_on ? stuck[addr] : '0)) : 8'hC3;

  always @(posedge clk) begin
    if (erase_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (!ce_n && vpp_hi && wr_en) begin
      mem[addr] <= mem[addr] & wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr != p_addr && !ce_n) v_addr++;
      if (wr_en && !p_vpp) v_settle++;
      if (!ce_n && !vpp_hi && p_vpp) v_settle++;
      if (wr_en && (ce_n || !vpp_hi || !oe_n)) v_mode++;
      if (!oe_n && vpp_hi) v_mode++;
      if (done && p_done) v_done++;
      if (done) done_total++;
      if (wr_en) pulse_total++;
      if (!ce_n && !oe_n) read_total++;
    end
    p_addr = addr; p_vpp = vpp_hi; p_done = done;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat_byte(input int a, input logic [1:0] s);
    logic [DW-1:0] c;
    c = ((a & 1) ^ ((a >> ROW) & 1)) != 0 ? 8'h55 : 8'hAA;
    case (s)
      2'b00: return c;
      2'b01: return ~c;
      2'b10: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic erase();
    @(negedge clk); erase_req = 1'b1;
    @(negedge clk); erase_req = 1'b0;
  endtask

  task automatic launch(input logic b, input logic [1:0] s);
    @(negedge clk); blank_run = b; pat_sel = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_dones(input int base, input int n);
    int t = 0;
    while (done_total < base + n && t < 2000) begin
      @(negedge clk); t++;
    end
    if (t >= 2000) chk("R11 done timeout", done_total - base, n);
    @(negedge clk);
  endtask

  task automatic expect_status(input logic b, input logic [1:0] s,
                               output int ep, output int ea, output int ec);
    ep = 1; ea = 0; ec = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] e, r, d;
      e = b ? 8'hFF : pat_byte(a, s);
      r = mem[a] | (fault_on ? stuck[a] : '0);
      d = e ^ r;
      if (d != 0 && ep == 1) begin ep = 0; ea = a; end
      ec += $countones(d);
    end
    if (ec > (1 << CW) - 1) ec = (1 << CW) - 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '1; stuck[i] = '0; end
    stuck[5] = 8'h01; stuck[9] = 8'h18; stuck[40] = 8'h80;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", ce_n, 1); chk("R1 oe_n", oe_n, 1); chk("R1 vpp_hi", vpp_hi, 0);
    chk("R1 wr_en", wr_en, 0); chk("R1 done", done, 0); chk("R1 pass", pass, 1);
    chk("R1 fail_addr", fail_addr, 0); chk("R1 err_bits", err_bits, 0);
    chk("R1 addr", addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {ce_n, oe_n, vpp_hi, done}, 4'b1100);

    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] e = VEC[v];
      int b0, p0, r0, ep, ea, ec, bad;
      if (e[4]) erase();
      fault_on = e[3];
      b0 = done_total; p0 = pulse_total; r0 = read_total;
      launch(e[2], e[1:0]);
      wait_dones(b0, e[2] ? 1 : 2);
      expect_status(e[2], e[1:0], ep, ea, ec);
      chk("R11 done count", done_total - b0, e[2] ? 1 : 2);
      chk("R2 R3 program cycles", pulse_total - p0, e[2] ? 0 : DEPTH);
      chk("R2 R4 read cycles", read_total - r0, DEPTH);
      chk("R9 R8 R13 pass", pass, ep);
      if (ep == 0) chk("R9 fail_addr", fail_addr, ea);
      chk("R10 R13 err_bits", err_bits, ec);
      if (!e[2]) begin
        bad = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[a] != pat_byte(a, e[1:0])) bad++;
        chk("R7 programmed bytes", bad, 0);
      end
    end

    // R12: second start mid-run must not disturb the flow
    begin
      int b0, bad;
      erase();
      fault_on = 1'b0;
      b0 = done_total;
      launch(1'b0, 2'b00);
      repeat (10) @(negedge clk);
      launch(1'b1, 2'b10);
      wait_dones(b0, 2);
      repeat (6) @(negedge clk);
      chk("R12 done count", done_total - b0, 2);
      chk("R12 pass", pass, 1);
      bad = 0;
      for (int a = 0; a < DEPTH; a++) if (mem[a] != 8'hAA && mem[a] != 8'h55) bad++;
      chk("R12 pattern kept", bad, 0);
    end

    chk("R5 address moved with ce_n low", v_addr, 0);
    chk("R6 settle cycle missing", v_settle, 0);
    chk("R3 R4 bus mode", v_mode, 0);
    chk("R11 done longer than one cycle", v_done, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule